// File: doc/BRIEF.md
# Idle Clock-Tile Delay-Line Keep-Alive Controller

This block looks after a clock-management tile whose input clock can disappear. The tile's internal delay lines age if they sit at a fixed logic level for a long time. A clock-presence detector drives `clk_lost`. When it rises, the controller uses the tile's dynamic reconfiguration port to read three configuration registers and keep their values. It then silences the tile outputs and writes a fixed pattern of values over and over, so the delay lines keep switching.

When `clk_lost` falls again, the controller writes the saved values back into the tile and pulses the tile reset. It then returns to idle. The three saved words are held in a short rotating shift chain, so no addressed memory is needed. All sequencing is done by one state machine that advances on the port's ready handshake.

Top module: `dlyline_keepalive`

## Requirements
- R1: After reset, and while `clk_lost` is low in idle, `port_en` and `tile_rst` stay 0 and no port access is made.
- R2: When `clk_lost` is seen high in idle, the controller first reads (`port_we`=0) addresses 42h, 51h and 4Eh, in that order.
- R3: Straight after the three reads, it writes 0000h to address 4Eh.
- R4: It then writes 00A0h to 42h, 00A1h to 51h, 00B0h to 42h and 00B1h to 51h, and repeats this four-write group for as long as `clk_lost` stays high.
- R5: Each access drives `port_en` high for exactly one cycle. The next access starts only after `port_rdy` has been seen, and read data is taken from `port_rdata` in the cycle where `port_rdy` is high.
- R6: Once `clk_lost` is low at the end of an access, the controller writes the saved values back to 42h, 51h and 4Eh, in that order.
- R7: If `clk_lost` falls while an access is in flight, that access finishes and the restore writes follow with no further pattern writes. If it falls during the reads, all three reads and the 4Eh silencing write still complete before the restore.
- R8: After the last restore write is acknowledged, `tile_rst` goes high for exactly RST_CYCLES cycles (3 by default), with no port access during the pulse. The controller is then idle.
- R9: If `clk_lost` is high when the controller returns to idle, a new save sequence starts at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_lost | input | 1 | High while the detector reports no tile input clock |
| port_en | output | 1 | One-cycle access strobe to the reconfiguration port |
| port_we | output | 1 | 1 = write access, 0 = read access |
| port_addr | output | 7 | Register address for the access |
| port_wdata | output | 16 | Write data |
| port_rdata | input | 16 | Read data, valid when `port_rdy` is high |
| port_rdy | input | 1 | Access completion from the tile |
| tile_rst | output | 1 | Reset pulse to the clock tile |

## Verification
The bound checker watches the port handshake on every cycle. It checks that the strobe lasts one cycle, that no access starts while another is open, that reads only go to the three saved addresses, that `tile_rst` never overlaps an access, and that the reset pulse has the right length. The order of the accesses and their data can only be shown by the bench's scenarios. These cover the exact read, silence and pattern sequence, that the saved values come back intact, that the in-flight access finishes when the clock returns mid-write or mid-save, and that the controller starts again when the clock is still missing.

// File: rtl/dlk_pkg.sv
// Package: shared sequencing types for the keep-alive controller.
// Assumes: nothing; holds only type definitions.
package dlk_pkg;
    // Which part of the keep-alive sequence is running.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SAVE,
        PH_MUTE,
        PH_LOOP,
        PH_RESTORE,
        PH_PULSE
    } phase_t;

    // Handshake sub-state of the current port access.
    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_ISSUE,
        ACC_WAIT
    } acc_t;
endpackage

// File: rtl/dlk_save_chain.sv
// Module: rotating shift chain that holds saved register words.
// Each shift moves stage k+1 into stage k and loads din into the last stage.
// Assumes: the caller feeds head back into din when it wants to rotate.
module dlk_save_chain #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] head
);
    logic [DEPTH-1:0][DATA_W-1:0] stage_q;
    logic [DEPTH-1:0][DATA_W-1:0] stage_nxt;

    // Next value of each stage: its upper neighbour, or din for the last one.
    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_stage
            if (g == DEPTH - 1) begin : g_tail
                assign stage_nxt[g] = din;
            end else begin : g_body
                assign stage_nxt[g] = stage_q[g+1];
            end
        end
    endgenerate

    // Chain register: moves one place per shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else if (shift) begin
            stage_q <= stage_nxt;
        end
    end

    assign head = stage_q[0];
endmodule

// File: rtl/dlk_rst_pulse.sv
// Module: fixed-length reset pulse generator.
// A start strobe loads LEN; active stays high for LEN cycles.
// Assumes: LEN >= 1 and start is not repeated while active.
module dlk_rst_pulse #(
    parameter int LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active,
    output logic last
);
    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] cnt_q;

    // Down-counter of the remaining pulse cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CW'(LEN);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign active = (cnt_q != '0);
    assign last   = (cnt_q == CW'(1));
endmodule

// File: rtl/dlyline_keepalive.sv
// Module: keep-alive controller for an idle clock-management tile.
// Saves three tile registers, silences the outputs, and writes a toggling
// pattern while the input clock is missing. It then restores the registers
// and pulses the tile reset.
// Assumes: the tile acknowledges every access with one port_rdy pulse, and
// clk_lost is already synchronous to clk.
module dlyline_keepalive #(
    parameter int              ADDR_W     = 7,
    parameter int              DATA_W     = 16,
    parameter logic [ADDR_W-1:0] ADDR_A   = 7'h42,
    parameter logic [ADDR_W-1:0] ADDR_B   = 7'h51,
    parameter logic [ADDR_W-1:0] ADDR_C   = 7'h4E,
    parameter logic [DATA_W-1:0] MUTE_VAL = 16'h0000,
    parameter logic [DATA_W-1:0] PAT0     = 16'h00A0,
    parameter logic [DATA_W-1:0] PAT1     = 16'h00A1,
    parameter logic [DATA_W-1:0] PAT2     = 16'h00B0,
    parameter logic [DATA_W-1:0] PAT3     = 16'h00B1,
    parameter int              RST_CYCLES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_lost,
    output logic              port_en,
    output logic              port_we,
    output logic [ADDR_W-1:0] port_addr,
    output logic [DATA_W-1:0] port_wdata,
    input  logic [DATA_W-1:0] port_rdata,
    input  logic              port_rdy,
    output logic              tile_rst
);
    import dlk_pkg::*;

    localparam int SAVE_N = 3;
    localparam int LOOP_N = 4;
    localparam int STEP_W = $clog2(LOOP_N);
    localparam logic [STEP_W-1:0] SAVE_LAST = STEP_W'(SAVE_N - 1);
    localparam logic [STEP_W-1:0] LOOP_LAST = STEP_W'(LOOP_N - 1);

    phase_t              phase_q;
    acc_t                acc_q;
    logic [STEP_W-1:0]   step_q;
    logic                acc_done;
    logic                chain_shift;
    logic [DATA_W-1:0]   chain_din;
    logic [DATA_W-1:0]   chain_head;
    logic                pulse_start;
    logic                pulse_last;
    logic [ADDR_W-1:0]   save_addr;

    // Address of a saved register, by position in the save order.
    always_comb begin
        case (step_q)
            2'd0:    save_addr = ADDR_A;
            2'd1:    save_addr = ADDR_B;
            default: save_addr = ADDR_C;
        endcase
    end

    // Port outputs decoded from phase and step.
    always_comb begin
        port_en    = (acc_q == ACC_ISSUE);
        port_we    = 1'b1;
        port_addr  = save_addr;
        port_wdata = chain_head;
        case (phase_q)
            PH_SAVE: port_we = 1'b0;
            PH_MUTE: begin
                port_addr  = ADDR_C;
                port_wdata = MUTE_VAL;
            end
            PH_LOOP: begin
                port_addr = step_q[0] ? ADDR_B : ADDR_A;
                case (step_q)
                    2'd0:    port_wdata = PAT0;
                    2'd1:    port_wdata = PAT1;
                    2'd2:    port_wdata = PAT2;
                    default: port_wdata = PAT3;
                endcase
            end
            default: ;
        endcase
    end

    // Handshake completion and the side effects that depend on it.
    assign acc_done    = (acc_q == ACC_WAIT) && port_rdy;
    assign chain_shift = acc_done && (phase_q == PH_SAVE || phase_q == PH_RESTORE);
    assign chain_din   = (phase_q == PH_SAVE) ? port_rdata : chain_head;
    assign pulse_start = acc_done && (phase_q == PH_RESTORE) && (step_q == SAVE_LAST);

    // Unified sequencer: phase, step and access handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            acc_q   <= ACC_NONE;
            step_q  <= '0;
        end else begin
            case (acc_q)
                ACC_ISSUE: acc_q <= ACC_WAIT;
                ACC_WAIT: if (port_rdy) begin
                    acc_q <= ACC_ISSUE;
                    case (phase_q)
                        PH_SAVE: begin
                            if (step_q == SAVE_LAST) begin
                                phase_q <= PH_MUTE;
                                step_q  <= '0;
                            end else begin
                                step_q <= step_q + 1'b1;
                            end
                        end
                        PH_MUTE: begin
                            phase_q <= clk_lost ? PH_LOOP : PH_RESTORE;
                            step_q  <= '0;
                        end
                        PH_LOOP: begin
                            if (!clk_lost) begin
                                phase_q <= PH_RESTORE;
                                step_q  <= '0;
                            end else begin
                                step_q <= (step_q == LOOP_LAST) ? '0 : step_q + 1'b1;
                            end
                        end
                        PH_RESTORE: begin
                            if (step_q == SAVE_LAST) begin
                                phase_q <= PH_PULSE;
                                acc_q   <= ACC_NONE;
                                step_q  <= '0;
                            end else begin
                                step_q <= step_q + 1'b1;
                            end
                        end
                        default: acc_q <= ACC_NONE;
                    endcase
                end
                default: begin
                    if (phase_q == PH_IDLE && clk_lost) begin
                        phase_q <= PH_SAVE;
                        step_q  <= '0;
                        acc_q   <= ACC_ISSUE;
                    end else if (phase_q == PH_PULSE && pulse_last) begin
                        phase_q <= PH_IDLE;
                    end
                end
            endcase
        end
    end

    dlk_save_chain #(
        .DATA_W (DATA_W),
        .DEPTH  (SAVE_N)
    ) u_chain (
        .clk   (clk),
        .rst_n (rst_n),
        .shift (chain_shift),
        .din   (chain_din),
        .head  (chain_head)
    );

    dlk_rst_pulse #(
        .LEN (RST_CYCLES)
    ) u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (pulse_start),
        .active (tile_rst),
        .last   (pulse_last)
    );
endmodule

// File: rtl/dlk_checker.sv
// Module: cycle-level property checker for dlyline_keepalive, attached by bind.
// Assumes: the tile answers each strobe with one port_rdy pulse.
module dlk_checker #(
    parameter int              ADDR_W     = 7,
    parameter logic [ADDR_W-1:0] ADDR_A   = 7'h42,
    parameter logic [ADDR_W-1:0] ADDR_B   = 7'h51,
    parameter logic [ADDR_W-1:0] ADDR_C   = 7'h4E,
    parameter int              RST_CYCLES = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              port_en,
    input logic              port_we,
    input logic [ADDR_W-1:0] port_addr,
    input logic              port_rdy,
    input logic              tile_rst
);
    logic open_q;
    int   hi_cnt_q;

    // Tracks whether an access is waiting for its ready.
    always_ff @(posedge clk) begin
        if (!rst_n)        open_q <= 1'b0;
        else if (port_en)  open_q <= 1'b1;
        else if (port_rdy) open_q <= 1'b0;
    end

    // Counts the consecutive cycles tile_rst has been high.
    always_ff @(posedge clk) begin
        if (!rst_n)        hi_cnt_q <= 0;
        else if (tile_rst) hi_cnt_q <= hi_cnt_q + 1;
        else               hi_cnt_q <= 0;
    end

    assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        port_en |=> !port_en);

    assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        port_en |-> !open_q);

    assert_read_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (port_en && !port_we) |->
        (port_addr == ADDR_A || port_addr == ADDR_B || port_addr == ADDR_C));

    assert_rst_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tile_rst |-> (!port_en && !open_q));

    assert_rst_length_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tile_rst) |-> (hi_cnt_q == RST_CYCLES));
endmodule

bind dlyline_keepalive dlk_checker #(
    .ADDR_W     (ADDR_W),
    .ADDR_A     (ADDR_A),
    .ADDR_B     (ADDR_B),
    .ADDR_C     (ADDR_C),
    .RST_CYCLES (RST_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .port_en   (port_en),
    .port_we   (port_we),
    .port_addr (port_addr),
    .port_rdy  (port_rdy),
    .tile_rst  (tile_rst)
);

// File: tb/dlyline_keepalive_test.sv
// Bench: directed scenarios against a behavioural clock-tile register model.
module dlyline_keepalive_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_lost = 1'b0;
    logic        port_en, port_we, port_rdy, tile_rst;
    logic [6:0]  port_addr;
    logic [15:0] port_wdata, port_rdata;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dlyline_keepalive uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_lost   (clk_lost),
        .port_en    (port_en),
        .port_we    (port_we),
        .port_addr  (port_addr),
        .port_wdata (port_wdata),
        .port_rdata (port_rdata),
        .port_rdy   (port_rdy),
        .tile_rst   (tile_rst)
    );

    // Tile model state and access log.
    logic [15:0] regs [0:127];
    logic [15:0] rd_hold;
    int          lat = 1;
    int          cnt = 0;
    logic        busy = 1'b0;
    logic [6:0]  log_addr [0:255];
    logic        log_we   [0:255];
    logic [15:0] log_data [0:255];
    int          log_n = 0;
    int          overlap = 0;
    int          pulse_len = 0, last_pulse = 0, pulses = 0, en_in_rst = 0;

    // Tile model: registers, ready after lat cycles, read data only on ready.
    always @(posedge clk) begin
        port_rdy   <= 1'b0;
        port_rdata <= 16'hDEAD;
        if (!rst_n) begin
            busy <= 1'b0;
        end else if (port_en) begin
            if (busy) overlap <= overlap + 1;
            busy <= 1'b1;
            cnt  <= lat - 1;
            if (log_n < 256) begin
                log_addr[log_n] <= port_addr;
                log_we[log_n]   <= port_we;
                log_data[log_n] <= port_we ? port_wdata : regs[port_addr];
            end
            log_n <= log_n + 1;
            if (port_we) regs[port_addr] <= port_wdata;
            else         rd_hold <= regs[port_addr];
        end else if (busy) begin
            if (cnt == 0) begin
                port_rdy   <= 1'b1;
                port_rdata <= rd_hold;
                busy       <= 1'b0;
            end else begin
                cnt <= cnt - 1;
            end
        end
        if (tile_rst) begin
            pulse_len <= pulse_len + 1;
            if (port_en) en_in_rst <= en_in_rst + 1;
        end else if (pulse_len != 0) begin
            last_pulse <= pulse_len;
            pulse_len  <= 0;
            pulses     <= pulses + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_log(input int n);
        while (log_n < n) @(negedge clk);
    endtask

    task automatic wait_pulse(input int n);
        while (pulses < n) @(negedge clk);
    endtask

    // Checks one logged access against its expected kind, address and data.
    task automatic chk_entry(input string req, input int i, input logic we,
                             input logic [6:0] a, input logic [15:0] d);
        chk({req, " we"},   32'(log_we[i]),   32'(we));
        chk({req, " addr"}, 32'(log_addr[i]), 32'(a));
        chk({req, " data"}, 32'(log_data[i]), 32'(d));
    endtask

    task automatic t_reset_idle();
        chk("R1 port_en after reset", 32'(port_en), 32'd0);
        chk("R1 tile_rst after reset", 32'(tile_rst), 32'd0);
        repeat (20) @(negedge clk);
        chk("R1 no access while idle", 32'(log_n), 32'd0);
    endtask

    task automatic t_full_sequence();
        int base;
        int p;
        int n;
        base = log_n;
        lat  = 2;
        clk_lost = 1'b1;
        wait_log(base + 12);
        chk_entry("R2 save 0", base + 0, 1'b0, 7'h42, 16'h1234);
        chk_entry("R2 save 1", base + 1, 1'b0, 7'h51, 16'h5678);
        chk_entry("R2 save 2", base + 2, 1'b0, 7'h4E, 16'h9ABC);
        chk_entry("R3 mute", base + 3, 1'b1, 7'h4E, 16'h0000);
        for (int k = 0; k < 8; k++) begin
            case (k % 4)
                0: chk_entry("R4 pattern", base + 4 + k, 1'b1, 7'h42, 16'h00A0);
                1: chk_entry("R4 pattern", base + 4 + k, 1'b1, 7'h51, 16'h00A1);
                2: chk_entry("R4 pattern", base + 4 + k, 1'b1, 7'h42, 16'h00B0);
                default: chk_entry("R4 pattern", base + 4 + k, 1'b1, 7'h51, 16'h00B1);
            endcase
        end
        p = pulses;
        clk_lost = 1'b0;
        wait_pulse(p + 1);
        n = log_n;
        chk_entry("R6 restore 42h", n - 3, 1'b1, 7'h42, 16'h1234);
        chk_entry("R6 restore 51h", n - 2, 1'b1, 7'h51, 16'h5678);
        chk_entry("R6 restore 4Eh", n - 1, 1'b1, 7'h4E, 16'h9ABC);
        chk("R5 read data taken on ready", 32'(regs[7'h4E]), 32'h9ABC);
        chk("R5 no overlapping access", 32'(overlap), 32'd0);
        chk("R8 pulse length", 32'(last_pulse), 32'd3);
        chk("R8 no access during pulse", 32'(en_in_rst), 32'd0);
        repeat (20) @(negedge clk);
        chk("R1 idle after pulse", 32'(log_n), 32'(n));
    endtask

    task automatic t_return_mid_write();
        int base;
        int p;
        base = log_n;
        lat  = 6;
        p    = pulses;
        clk_lost = 1'b1;
        wait_log(base + 6);
        clk_lost = 1'b0;
        wait_pulse(p + 1);
        chk("R7 access count mid write", 32'(log_n), 32'(base + 9));
        chk_entry("R7 in-flight write", base + 5, 1'b1, 7'h51, 16'h00A1);
        chk_entry("R7 restore 42h", base + 6, 1'b1, 7'h42, 16'h1234);
        chk_entry("R7 restore 51h", base + 7, 1'b1, 7'h51, 16'h5678);
        chk_entry("R7 restore 4Eh", base + 8, 1'b1, 7'h4E, 16'h9ABC);
        chk("R8 pulse length slow tile", 32'(last_pulse), 32'd3);
    endtask

    task automatic t_return_mid_save();
        int base;
        int p;
        base = log_n;
        lat  = 3;
        p    = pulses;
        clk_lost = 1'b1;
        wait_log(base + 1);
        clk_lost = 1'b0;
        wait_pulse(p + 1);
        chk("R7 access count mid save", 32'(log_n), 32'(base + 7));
        chk_entry("R7 save completes", base + 2, 1'b0, 7'h4E, 16'h9ABC);
        chk_entry("R7 mute still issued", base + 3, 1'b1, 7'h4E, 16'h0000);
        chk_entry("R7 restore first", base + 4, 1'b1, 7'h42, 16'h1234);
        chk_entry("R7 restore last", base + 6, 1'b1, 7'h4E, 16'h9ABC);
    endtask

    task automatic t_reentry();
        int base;
        int p;
        int n_at;
        base = log_n;
        lat  = 1;
        p    = pulses;
        clk_lost = 1'b1;
        wait_log(base + 5);
        clk_lost = 1'b0;
        while (!tile_rst) @(negedge clk);
        clk_lost = 1'b1;
        n_at = log_n;
        wait_pulse(p + 1);
        wait_log(n_at + 1);
        chk_entry("R9 new save starts", n_at, 1'b0, 7'h42, 16'h1234);
        clk_lost = 1'b0;
        wait_pulse(p + 2);
        chk("R9 second restore 4Eh", 32'(regs[7'h4E]), 32'h9ABC);
    endtask

    initial begin
        for (int i = 0; i < 128; i++) regs[i] = 16'(i * 3);
        regs[7'h42] = 16'h1234;
        regs[7'h51] = 16'h5678;
        regs[7'h4E] = 16'h9ABC;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_idle();
        t_full_sequence();
        t_return_mid_write();
        t_return_mid_save();
        t_reentry();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run is counted as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R1..R9 run actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule